// File: doc/BRIEF.md
# External Interrupt Pin Trigger

This block turns an asynchronous, active-low interrupt pin into a clean request for the interrupt arbiter. The pin passes through a flop chain into the core clock domain. A falling edge is detected on the synchronized copy and captured in a request latch. The latch holds the event until the service routine acknowledges it. Because of this, a short pulse is not lost when it arrives while interrupts are masked.

A mode input selects between two trigger behaviours. In edge-only mode, only a falling edge creates a request. In level-plus-edge mode, a falling edge is still latched, and a pin that stays low also keeps the request asserted. The global mask gates the request toward the arbiter. The mask never discards a latched event.

Top module: `extirq_trigger`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after reset, `irq_req` is 0 and no event is held, whatever the levels of `pin_n` and `level_mode`.
- R2: In edge-only mode (`level_mode`=0) with the mask clear, a falling edge on `pin_n` raises `irq_req` on the third rising clock edge after the fall: two synchronizer stages, then the latch. Even a pin low for a single clock cycle is captured.
- R3: In edge-only mode, a pin held low does not re-assert `irq_req` once an acknowledge has cleared the latch.
- R4: In level-plus-edge mode (`level_mode`=1) with the mask clear, `irq_req` is high from the second rising edge after the pin falls. It stays high for as long as the synchronized pin is low, including after an acknowledge.
- R5: A `svc_ack` pulse, with no falling edge detected in that cycle, clears the latched event. `irq_req` then drops after that clock edge, provided the pin is high.
- R6: While `irq_mask` is 1, `irq_req` is 0.
- R7: An event latched while `irq_mask` is 1 is kept. `irq_req` goes high in the same cycle that the mask is cleared.
- R8: When a falling edge is detected in the same cycle as `svc_ack`, the latch stays set, and `irq_req` remains high after the acknowledge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_n | input | 1 | Asynchronous active-low interrupt pin |
| level_mode | input | 1 | 0 = edge-only trigger, 1 = level-plus-edge trigger |
| irq_mask | input | 1 | Global interrupt mask; 1 blocks the request |
| svc_ack | input | 1 | One-cycle pulse at the start of service; clears the latch |
| irq_req | output | 1 | Request toward the interrupt arbiter |

## Verification
On every cycle, the assertions check four things. A detected fall always leaves the latch set, so the edge wins over the acknowledge. An acknowledge with no fall always empties the latch. The mask always suppresses the request. A held latch, or in level mode a low synchronized pin, always yields a request when unmasked. The bench sweeps both modes, both mask states and several pulse widths, and compares against delays computed from the pipeline depth. Only those scenarios show the exact latency from the pin, that a masked pulse is still serviced after unmasking, and that a pin held low behaves differently in the two modes after an acknowledge.

// File: rtl/extirq_pkg.sv
// Package: shared types and constants for the external interrupt trigger.
// Assumes: nothing beyond IEEE 1800-2017.
package extirq_pkg;

    // Trigger behaviour selected by the mode input.
    typedef enum logic {
        TRIG_EDGE_ONLY  = 1'b0,
        TRIG_LEVEL_EDGE = 1'b1
    } trig_mode_e;

    // Default synchronizer depth.
    localparam int unsigned DEFAULT_SYNC_STAGES = 2;

endpackage

// File: rtl/extirq_sync.sv
// Module: extirq_sync
// Brings an asynchronous active-low pin into the clk domain through a
// chain of STAGES flops. The chain resets to the idle (high) level.
// Assumes: STAGES >= 1; the pin idles high.
module extirq_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async_n,
    output logic pin_sync_n
);

    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            // Single-flop capture of the pin.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= 1'b1;
                else        chain_q <= pin_async_n;
            end
        end else begin : g_chain
            // Shift the pin level along the synchronizer chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= {chain_q[STAGES-2:0], pin_async_n};
            end
        end
    endgenerate

    assign pin_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/extirq_edge.sv
// Module: extirq_edge
// Detects a high-to-low transition of the synchronized pin. Gives a
// one-cycle pulse in the cycle where the new low level first appears.
// Assumes: the input is already synchronous to clk.
module extirq_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_n,
    output logic fall
);

    logic prev_q;

    // Remember the previous synchronized level.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= lvl_n;
    end

    assign fall = prev_q & ~lvl_n;

endmodule

// File: rtl/extirq_latch.sv
// Module: extirq_latch
// Set/clear request latch. A set wins over a clear in the same cycle,
// so an edge arriving with an acknowledge is never lost.
// Assumes: set and clr are synchronous to clk.
module extirq_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic q
);

    // Hold the pending event until it is acknowledged.
    always_ff @(posedge clk) begin
        if (!rst_n)   q <= 1'b0;
        else if (set) q <= 1'b1;
        else if (clr) q <= 1'b0;
    end

endmodule

// File: rtl/extirq_trigger.sv
// Module: extirq_trigger (top)
// Conditions the active-low interrupt pin into a masked request for the
// arbiter. The chain is: synchronizer, falling-edge detect, request
// latch, then mode selection and masking.
// Assumes: svc_ack is a single-cycle pulse at the start of service, and
// level_mode and irq_mask are synchronous to clk.
module extirq_trigger
    import extirq_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = DEFAULT_SYNC_STAGES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    input  logic level_mode,
    input  logic irq_mask,
    input  logic svc_ack,
    output logic irq_req
);

    logic       pin_s;
    logic       fall_pulse;
    logic       latch_q;
    logic       level_hit;
    logic       pending;
    trig_mode_e mode;

    extirq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk         (clk),
        .rst_n       (rst_n),
        .pin_async_n (pin_n),
        .pin_sync_n  (pin_s)
    );

    extirq_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl_n (pin_s),
        .fall  (fall_pulse)
    );

    extirq_latch u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (fall_pulse),
        .clr   (svc_ack),
        .q     (latch_q)
    );

    // Combine latched edge and optional level, then apply the mask.
    always_comb begin
        mode      = trig_mode_e'(level_mode);
        level_hit = (mode == TRIG_LEVEL_EDGE) && !pin_s;
        pending   = latch_q || level_hit;
        irq_req   = pending && !irq_mask;
    end

endmodule

// File: rtl/extirq_trigger_checker.sv
// Module: extirq_trigger_checker
// Cycle-by-cycle properties of the trigger, attached to the top by bind.
// Assumes: synchronous active-low reset; the signals are sampled at posedge clk.
module extirq_trigger_checker (
    input logic clk,
    input logic rst_n,
    input logic level_mode,
    input logic irq_mask,
    input logic svc_ack,
    input logic irq_req,
    input logic pin_s,
    input logic fall,
    input logic latch_q
);

    // R2: a fall on the synchronized pin is captured by the next edge.
    assert_fall_latched_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pin_s) |=> latch_q);

    // R8: an edge coincident with an acknowledge keeps the latch set.
    assert_edge_beats_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fall && svc_ack) |=> latch_q);

    // R5: an acknowledge without an edge empties the latch.
    assert_ack_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_ack && !fall) |=> !latch_q);

    // R6: the mask blocks the request.
    assert_mask_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_mask |-> !irq_req);

    // R7: a held event is presented whenever unmasked.
    assert_held_presented_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_q && !irq_mask) |-> irq_req);

    // R4: in level mode a low synchronized pin requests when unmasked.
    assert_level_requests_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (level_mode && !pin_s && !irq_mask) |-> irq_req);

    // R3: in edge-only mode, without a held event, there is no request.
    assert_edge_only_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!level_mode && !latch_q) |-> !irq_req);

endmodule

bind extirq_trigger extirq_trigger_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .level_mode (level_mode),
    .irq_mask   (irq_mask),
    .svc_ack    (svc_ack),
    .irq_req    (irq_req),
    .pin_s      (pin_s),
    .fall       (fall_pulse),
    .latch_q    (latch_q)
);

// File: tb/extirq_trigger_test.sv
// Bench: sweeps trigger mode, mask and pulse width, with directed cases
// for acknowledge ordering. Inputs are driven and outputs sampled on negedge.
module extirq_trigger_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pin_n = 1'b1;
    logic level_mode = 1'b0;
    logic irq_mask = 1'b0;
    logic svc_ack = 1'b0;
    logic irq_req;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;  // 50 MHz

    extirq_trigger uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_n      (pin_n),
        .level_mode (level_mode),
        .irq_mask   (irq_mask),
        .svc_ack    (svc_ack),
        .irq_req    (irq_req)
    );

    task automatic check(input logic act, input logic exp, input string req, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: irq_req=%b expected=%b at %0t", req, what, act, exp, $time);
        end
    endtask

    // Return to idle: pin high, unmasked, latch cleared by an acknowledge.
    task automatic settle();
        pin_n    = 1'b1;
        irq_mask = 1'b0;
        svc_ack  = 1'b1;
        repeat (4) @(negedge clk);
        svc_ack = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R1: reset holds the request low even with the pin low in level mode.
        pin_n = 1'b0;
        level_mode = 1'b1;
        repeat (3) @(negedge clk);
        check(irq_req, 1'b0, "R1", "during reset");
        pin_n = 1'b1;
        level_mode = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(irq_req, 1'b0, "R1", "after reset");

        // Sweep mode x mask x pulse width (R2, R4, R6, R7, R5).
        for (int m = 0; m < 2; m++) begin
            for (int mk = 0; mk < 2; mk++) begin
                for (int len = 1; len <= 4; len++) begin
                    settle();
                    level_mode = m[0];
                    irq_mask   = mk[0];
                    pin_n      = 1'b0;
                    for (int k = 1; k <= 8; k++) begin
                        @(negedge clk);
                        begin
                            logic exp;
                            exp = !mk[0] && ((m[0] && k >= 2 && k < len + 2) || k >= 3);
                            check(irq_req, exp, mk[0] ? "R6" : (m[0] ? "R4" : "R2"), "sweep");
                        end
                        if (k == len) pin_n = 1'b1;
                    end
                    irq_mask = 1'b0;
                    #1;
                    check(irq_req, 1'b1, "R7", "held event after unmask");
                    svc_ack = 1'b1;
                    @(negedge clk);
                    svc_ack = 1'b0;
                    check(irq_req, 1'b0, "R5", "acknowledge clears");
                end
            end
        end

        // R3: edge-only mode, pin held low, no re-assert after acknowledge.
        settle();
        level_mode = 1'b0;
        pin_n = 1'b0;
        repeat (4) @(negedge clk);
        check(irq_req, 1'b1, "R3", "edge captured");
        svc_ack = 1'b1;
        @(negedge clk);
        svc_ack = 1'b0;
        for (int i = 0; i < 3; i++) begin
            check(irq_req, 1'b0, "R3", "held low after ack");
            @(negedge clk);
        end

        // R4: level mode, pin held low, request persists after acknowledge.
        settle();
        level_mode = 1'b1;
        pin_n = 1'b0;
        repeat (4) @(negedge clk);
        svc_ack = 1'b1;
        @(negedge clk);
        svc_ack = 1'b0;
        for (int i = 0; i < 3; i++) begin
            check(irq_req, 1'b1, "R4", "held low after ack");
            @(negedge clk);
        end
        pin_n = 1'b1;
        repeat (3) @(negedge clk);
        check(irq_req, 1'b0, "R4", "released pin");

        // R8: a fall detected in the acknowledge cycle keeps the latch set.
        settle();
        level_mode = 1'b0;
        pin_n = 1'b0;
        @(negedge clk);
        pin_n = 1'b1;
        repeat (4) @(negedge clk);
        check(irq_req, 1'b1, "R8", "first event held");
        pin_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        svc_ack = 1'b1;
        @(negedge clk);
        svc_ack = 1'b0;
        check(irq_req, 1'b1, "R8", "edge with ack");
        @(negedge clk);
        check(irq_req, 1'b1, "R8", "edge with ack, next cycle");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule